// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire bus. It works on bit events that a slot-timing front end has already decoded: a bus-reset pulse with a flag that tells a long reset from a short one, a strobe for each bit received from the master, and a request for each bit the master wants to read. After every reset it collects one 8-bit command. It then answers according to that command: it reads out its 64-bit identity, compares against an identity sent by the master, takes part in bit-wise search arbitration, or grants access without addressing.

Once addressing succeeds, the block raises `selected`. The function layer above takes over the bus while `selected` is high. If addressing fails, the block releases the bus and stays silent until the next reset. A separate `overdrive` flag tells the front end to use the faster slot timing. Only the two overdrive commands set this flag, and only a long reset clears it. The identity is a parameter; its check byte is assumed to be computed already.

Top module: `sw_rom_layer`

## Requirements
- R1: After any reset the block takes exactly 8 received bits, LSB first, as a command byte. The codes are 33h read, 55h match, F0h search, ECh conditional search, CCh skip, 3Ch overdrive skip and 69h overdrive match.
- R2: After the read command, each transmit request returns the next identity bit, starting at `ROM_ID[0]`. After the 64th request, `selected` rises on the next cycle.
- R3: During search, each identity bit is handled in three steps. The first transmit request returns the bit, the second returns its complement, and the next received bit is the master's choice. If that choice differs from the identity bit, the block drops out and answers every later request with 1 (bus released).
- R4: A search that completes all 64 bit triplets without a mismatch raises `selected` on the cycle after the last received bit.
- R5: The conditional search command uses the `alarm_ok` value present with the last command bit. If `alarm_ok` is 1, the block behaves as in R3 and R4. If it is 0, every transmit request returns 1 until the next reset.
- R6: After match, 64 received bits are compared with `ROM_ID`, LSB first. If all of them are equal, `selected` rises. If any bit differs, the block goes idle and never selects.
- R7: The skip command raises `selected` on the cycle after the last command bit.
- R8: Overdrive skip and overdrive match set `overdrive` on the cycle after the last command bit. Overdrive skip also selects at once. Overdrive match then performs R6.
- R9: A reset with `rst_long`=1 clears `overdrive`. A reset with `rst_long`=0 leaves it unchanged.
- R10: A reset aborts any state and clears `selected` on the next cycle. It wins over a received bit or a transmit request in the same cycle, and command reception restarts at bit 0.
- R11: An unknown command code puts the block into idle. Idle returns 1 on every request, ignores received bits and never selects.
- R12: Out of `rst_n`, `overdrive` and `selected` are 0 and `tx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: a bus reset was detected |
| rst_long | input | 1 | With `bus_rst`: 1 = long reset, 0 = short reset |
| bit_rx_vld | input | 1 | One-cycle strobe: a bit from the master is available |
| bit_rx_val | input | 1 | Value of the received bit |
| bit_tx_req | input | 1 | One-cycle strobe: the master reads a bit; `tx_bit` is consumed in this cycle |
| alarm_ok | input | 1 | Eligibility for conditional search |
| tx_bit | output | 1 | Bit to send on a read slot; 1 = release, 0 = pull low |
| overdrive | output | 1 | Fast slot timing in effect |
| selected | output | 1 | Function layer owns the bus |

## Verification
A bus reset can arrive in the same cycle as a received-bit strobe or a transmit request. The bench provokes both cases: once in the middle of a match and once in the middle of a read-out, by driving the reset and the strobe on the same edge. The result is judged through the normal interface. A skip command sent right afterwards must select after exactly eight bits, which shows that the colliding strobe was discarded and the bit count restarted at zero. The bench also checks that `selected` is low and that `overdrive` follows the reset length.

// File: rtl/sw_rom_layer.sv
module sw_rom_layer #(
  parameter int          ID_BITS = 64,
  parameter logic [ID_BITS-1:0] ROM_ID = 64'h9C5A3C0F1E2D4B3B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic rst_long,
  input  logic bit_rx_vld,
  input  logic bit_rx_val,
  input  logic bit_tx_req,
  input  logic alarm_ok,
  output logic tx_bit,
  output logic overdrive,
  output logic selected
);
  localparam int CMD_BITS = 8;
  localparam int CW = $clog2(ID_BITS);
  localparam logic [CMD_BITS-1:0] C_READ     = 8'h33;
  localparam logic [CMD_BITS-1:0] C_MATCH    = 8'h55;
  localparam logic [CMD_BITS-1:0] C_SRCH     = 8'hF0;
  localparam logic [CMD_BITS-1:0] C_CSRCH    = 8'hEC;
  localparam logic [CMD_BITS-1:0] C_SKIP     = 8'hCC;
  localparam logic [CMD_BITS-1:0] C_OD_SKIP  = 8'h3C;
  localparam logic [CMD_BITS-1:0] C_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {S_CMD, S_READ, S_MATCH, S_SRCH, S_SEL, S_IDLE} st_t;
  st_t                 st;
  logic [CW-1:0]       cnt;
  logic [1:0]          ph;
  logic [CMD_BITS-1:0] cmd_sr;
  logic                od_q;

  wire [CMD_BITS-1:0] cmd_nx   = {bit_rx_val, cmd_sr[CMD_BITS-1:1]};
  wire                last_cmd = (cnt == CW'(CMD_BITS - 1));
  wire                last_id  = (cnt == CW'(ID_BITS - 1));
  wire                id_bit   = ROM_ID[cnt];

  assign tx_bit    = (st == S_READ)              ? id_bit  :
                     (st == S_SRCH && ph == 2'd0) ? id_bit  :
                     (st == S_SRCH && ph == 2'd1) ? ~id_bit : 1'b1;
  assign overdrive = od_q;
  assign selected  = (st == S_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_CMD;
      cnt    <= '0;
      ph     <= '0;
      cmd_sr <= '0;
      od_q   <= 1'b0;
    end else if (bus_rst) begin
      st  <= S_CMD;
      cnt <= '0;
      ph  <= '0;
      if (rst_long) od_q <= 1'b0;
    end else begin
      case (st)
        S_CMD: if (bit_rx_vld) begin
          cmd_sr <= cmd_nx;
          cnt    <= cnt + 1'b1;
          if (last_cmd) begin
            cnt <= '0;
            ph  <= '0;
            case (cmd_nx)
              C_READ:     st <= S_READ;
              C_MATCH:    st <= S_MATCH;
              C_SRCH:     st <= S_SRCH;
              C_CSRCH:    st <= alarm_ok ? S_SRCH : S_IDLE;
              C_SKIP:     st <= S_SEL;
              C_OD_SKIP:  begin st <= S_SEL;   od_q <= 1'b1; end
              C_OD_MATCH: begin st <= S_MATCH; od_q <= 1'b1; end
              default:    st <= S_IDLE;
            endcase
          end
        end
        S_READ: if (bit_tx_req) begin
          cnt <= cnt + 1'b1;
          if (last_id) st <= S_SEL;
        end
        S_MATCH: if (bit_rx_vld) begin
          if (bit_rx_val != id_bit) st <= S_IDLE;
          else begin
            cnt <= cnt + 1'b1;
            if (last_id) st <= S_SEL;
          end
        end
        S_SRCH: case (ph)
          2'd0: if (bit_tx_req) ph <= 2'd1;
          2'd1: if (bit_tx_req) ph <= 2'd2;
          default: if (bit_rx_vld) begin
            ph <= 2'd0;
            if (bit_rx_val != id_bit) st <= S_IDLE;
            else begin
              cnt <= cnt + 1'b1;
              if (last_id) st <= S_SEL;
            end
          end
        endcase
        default: ;
      endcase
    end
  end

  AST_RST_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !selected); // R10
  AST_LONG_RST_CLEARS_OD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && rst_long) |=> !overdrive); // R9
  AST_SHORT_RST_KEEPS_OD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !rst_long && overdrive) |=> overdrive); // R9
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_rst) |=> selected); // R4
  AST_SEARCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SRCH && ph == 2'd0 && bit_tx_req && !bus_rst) |=> (tx_bit != $past(tx_bit))); // R3
  AST_OD_BY_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdrive) |-> $past(bit_rx_vld && st == S_CMD)); // R8
  AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(bit_rx_vld || bit_tx_req)); // R7
endmodule

// File: tb/test_sw_rom_layer.sv
module test_sw_rom_layer;
  localparam logic [63:0] ID = 64'h9C5A3C0F1E2D4B3B;
  localparam int NV = 11;
  // fields: [13:6] command, [5] alarm_ok, [4:2] action, [1] expected selected, [0] expected overdrive
  // action: 0 none, 1 read, 2 match ok, 3 match bad, 4 search ok, 5 search bad, 6 silent
  localparam logic [13:0] VEC [NV] = '{
    {8'h33, 1'b0, 3'd1, 1'b1, 1'b0},
    {8'h55, 1'b0, 3'd2, 1'b1, 1'b0},
    {8'h55, 1'b0, 3'd3, 1'b0, 1'b0},
    {8'hF0, 1'b0, 3'd4, 1'b1, 1'b0},
    {8'hF0, 1'b0, 3'd5, 1'b0, 1'b0},
    {8'hEC, 1'b1, 3'd4, 1'b1, 1'b0},
    {8'hEC, 1'b0, 3'd6, 1'b0, 1'b0},
    {8'hCC, 1'b0, 3'd0, 1'b1, 1'b0},
    {8'h3C, 1'b0, 3'd0, 1'b1, 1'b1},
    {8'h69, 1'b0, 3'd2, 1'b1, 1'b1},
    {8'hA7, 1'b0, 3'd6, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, rst_long = 1'b0;
  logic bit_rx_vld = 1'b0, bit_rx_val = 1'b0, bit_tx_req = 1'b0, alarm_ok = 1'b0;
  logic tx_bit, overdrive, selected;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sw_rom_layer #(.ROM_ID(ID)) i_sw_rom_layer (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rst_long(rst_long),
    .bit_rx_vld(bit_rx_vld), .bit_rx_val(bit_rx_val), .bit_tx_req(bit_tx_req),
    .alarm_ok(alarm_ok), .tx_bit(tx_bit), .overdrive(overdrive), .selected(selected));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rst(input bit lng);
    @(negedge clk); bus_rst = 1'b1; rst_long = lng;
    @(negedge clk); bus_rst = 1'b0; rst_long = 1'b0;
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); bit_rx_vld = 1'b1; bit_rx_val = b;
    @(negedge clk); bit_rx_vld = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic get_bit(output logic b);
    @(negedge clk); b = tx_bit; bit_tx_req = 1'b1;
    @(negedge clk); bit_tx_req = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] v;
    logic b, c;
    int bad;
    repeat (3) @(negedge clk);
    chk(!overdrive && !selected && tx_bit, "R12 reset state", {overdrive, selected, tx_bit}, 3'b001);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      pulse_rst(1'b1);
      alarm_ok = v[5];
      put_byte(v[13:6]);
      bad = 0;
      case (v[4:2])
        3'd1: begin
          for (int i = 0; i < 64; i++) begin get_bit(b); if (b !== ID[i]) bad++; end
          chk(bad == 0, "R2 read identity bits", bad, 0);
        end
        3'd2: for (int i = 0; i < 64; i++) put_bit(ID[i]);
        3'd3: begin
          for (int i = 0; i < 64; i++) put_bit(i == 40 ? ~ID[i] : ID[i]);
          get_bit(b);
          chk(b === 1'b1, "R6 match mismatch idles", b, 1);
        end
        3'd4: begin
          for (int i = 0; i < 64; i++) begin
            get_bit(b); get_bit(c);
            if (b !== ID[i] || c !== ~ID[i]) bad++;
            put_bit(ID[i]);
          end
          chk(bad == 0, k == 5 ? "R5 conditional search triplets" : "R3 search triplets", bad, 0);
        end
        3'd5: begin
          for (int i = 0; i <= 20; i++) begin
            get_bit(b); get_bit(c);
            if (b !== ID[i] || c !== ~ID[i]) bad++;
            put_bit(i == 20 ? ~ID[i] : ID[i]);
          end
          for (int i = 0; i < 4; i++) begin get_bit(b); if (b !== 1'b1) bad++; end
          chk(bad == 0, "R3 search drop-out", bad, 0);
        end
        3'd6: begin
          for (int i = 0; i < 16; i++) begin get_bit(b); if (b !== 1'b1) bad++; end
          put_byte(8'hCC);
          chk(bad == 0 && !selected, k == 10 ? "R11 unknown code silent" : "R5 ineligible silent",
              {bad[7:0], selected}, 0);
        end
        default: ;
      endcase
      chk(selected === v[1], $sformatf("R1 row %0d selected (R4 R6 R7)", k), selected, v[1]);
      chk(overdrive === v[0], $sformatf("R8 row %0d overdrive", k), overdrive, v[0]);
    end

    pulse_rst(1'b1);
    put_byte(8'h3C);
    pulse_rst(1'b0);
    chk(overdrive === 1'b1, "R9 short reset keeps overdrive", overdrive, 1);
    chk(selected === 1'b0, "R10 reset deselects", selected, 0);
    put_byte(8'hCC);
    chk(selected === 1'b1, "R10 command after short reset", selected, 1);
    pulse_rst(1'b1);
    chk(overdrive === 1'b0, "R9 long reset clears overdrive", overdrive, 1'b0);

    put_byte(8'h55);
    for (int i = 0; i < 5; i++) put_bit(ID[i]);
    @(negedge clk); bus_rst = 1'b1; rst_long = 1'b1; bit_rx_vld = 1'b1; bit_rx_val = 1'b0;
    @(negedge clk); bus_rst = 1'b0; rst_long = 1'b0; bit_rx_vld = 1'b0;
    put_byte(8'hCC);
    chk(selected === 1'b1, "R10 reset wins over received bit", selected, 1);

    pulse_rst(1'b1);
    put_byte(8'h33);
    for (int i = 0; i < 3; i++) get_bit(b);
    @(negedge clk); bus_rst = 1'b1; rst_long = 1'b0; bit_tx_req = 1'b1;
    @(negedge clk); bus_rst = 1'b0; bit_tx_req = 1'b0;
    chk(selected === 1'b0, "R10 reset during read", selected, 0);
    for (int i = 0; i < 7; i++) put_bit(1'(8'hCC >> i));
    chk(selected === 1'b0, "R1 seven bits do not complete a command", selected, 0);
    put_bit(1'b1);
    chk(selected === 1'b1, "R7 skip selects after eighth bit", selected, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule